// File: doc/BRIEF.md
# Serial Word Packing Buffer

This block sits between a 32-bit processor-side data register and a serial shift register that moves words of 3 to 16 bits. A single pack control input chooses between two mappings. With packing off, each serial word occupies one buffer word. It is right-justified in the low half, and the upper half reads as zero. With packing on, two serial words share one buffer word. The earlier word sits in the low half and the later word in the high half, each right-justified in its half.

On the transmit side the processor loads a 32-bit word, and the shift register pulls one serial word at a time. On the receive side the shift register pushes serial words, and the processor reads whole 32-bit words. Each direction keeps a full/valid status bit and a sticky error flag, and it raises one interrupt pulse for each 32-bit buffer word.

The processor-side status always follows processor reads and writes, even while the port is off. The serial side does nothing while the port is off. Turning the port off also returns both half selectors to the low half.

Top module: `sport_pack_buf`

## Requirements
- R1: After reset, tx_full, tx_ovf, tx_irq, rx_valid, rx_ovr and rx_irq are 0, rx_rdata is 0 and tx_sword_vld is 0.
- R2: A processor write to a transmit buffer that is empty, or that is emptied by a final take in the same cycle, stores tx_wdata and shows tx_full = 1 from the next cycle. This happens whether the port is on or off.
- R3: With pack_en = 1, a full transmit word is offered as two serial words: bits 15:0 first, then bits 31:16 after the first take. tx_full clears, and tx_irq pulses for one cycle, only in the cycle after the second take.
- R4: With pack_en = 0, the serial word offered is bits 15:0 of the buffer. A single take clears tx_full, and tx_irq pulses in the following cycle.
- R5: The word length input L is clamped to 3..16. The offered tx_sword and every received serial word keep only their low L bits, and the remaining bits of the 16-bit half are zero. tx_sword is 0 whenever tx_sword_vld is 0.
- R6: A processor write while tx_full = 1, with no final take in that cycle, leaves the buffer unchanged and sets tx_ovf. tx_ovf then stays 1 until reset.
- R7: With pack_en = 1, the first received serial word lands in bits 15:0 and the second in bits 31:16. rx_valid rises and rx_irq pulses once, both only after the second word.
- R8: With pack_en = 0, each received serial word lands in bits 15:0 with bits 31:16 zero. rx_valid rises and rx_irq pulses for each word.
- R9: rx_rdata always shows the receive buffer. A processor read clears rx_valid on the next cycle, unless a new word completes in that same cycle, and this holds with the port on or off.
- R10: A serial word that completes a buffer word while rx_valid = 1, with no read in that cycle, is discarded together with any pending low half. The buffer is unchanged, and rx_ovr sets and stays 1 until reset.
- R11: While port_en = 0, tx_take and rx_push have no effect, and both half selectors return to the low half. The next packed transfer therefore starts with bits 15:0.
- R12: A final take together with a processor write, or a completing push together with a processor read, in the same cycle is accepted. The new word is stored, the status stays set, the interrupt pulses, and no error flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable |
| pack_en | input | 1 | 1 = two serial words per buffer word |
| word_len | input | 5 | Serial word length in bits, clamped to 3..16 |
| tx_wr | input | 1 | Processor write strobe for the transmit buffer |
| tx_wdata | input | 32 | Processor write data |
| tx_full | output | 1 | Transmit buffer holds unsent data |
| tx_ovf | output | 1 | Sticky: a write hit a full transmit buffer |
| tx_irq | output | 1 | One-cycle pulse when a transmit buffer word is fully sent |
| tx_take | input | 1 | Shift register takes the offered serial word |
| tx_sword | output | 16 | Serial word offered to the shift register |
| tx_sword_vld | output | 1 | tx_sword is valid |
| rx_push | input | 1 | Shift register delivers a serial word |
| rx_sword | input | 16 | Received serial word |
| rx_rd | input | 1 | Processor read strobe for the receive buffer |
| rx_rdata | output | 32 | Receive buffer contents |
| rx_valid | output | 1 | Receive buffer holds unread data |
| rx_ovr | output | 1 | Sticky: a completed word was discarded |
| rx_irq | output | 1 | One-cycle pulse when a receive buffer word completes |

## Verification
Two pairs of events can meet in one cycle. The first is the shift register's final take and a processor write. The second is the push that completes a receive word and a processor read. Each pair is forced once by a directed sequence with literal expected values, and then many times by random strobes, where a behavioural model decides from the requirements whether the word is stored or counted as an error. Both pairs are also run with the port turned off and with packing switched, so that half-select reset and the discard of a pending half are exercised at those collisions.

// File: rtl/sport_pack_pkg.sv
package sport_pack_pkg;

    localparam int BUF_W = 32;
    localparam int SER_W = 16;
    localparam int LEN_W = 5;
    localparam int MIN_LEN = 3;

    typedef struct packed {
        logic [BUF_W-1:0] data;
        logic             full;
        logic             half;
        logic             ovf;
        logic             irq;
    } tx_state_t;

    typedef struct packed {
        logic [BUF_W-1:0] data;
        logic [SER_W-1:0] lo;
        logic             half;
        logic             valid;
        logic             ovr;
        logic             irq;
    } rx_state_t;

endpackage

// File: rtl/sport_len_mask.sv
module sport_len_mask #(
    parameter int SER_W   = sport_pack_pkg::SER_W,
    parameter int LEN_W   = sport_pack_pkg::LEN_W,
    parameter int MIN_LEN = sport_pack_pkg::MIN_LEN
) (
    input  logic [LEN_W-1:0] word_len,
    output logic [SER_W-1:0] mask
);
    localparam logic [LEN_W-1:0] LO_C = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] HI_C = LEN_W'(SER_W);

    logic [LEN_W-1:0] len_c;

    always_comb begin
        if (word_len < LO_C)      len_c = LO_C;
        else if (word_len > HI_C) len_c = HI_C;
        else                      len_c = word_len;
    end

    for (genvar i = 0; i < SER_W; i++) begin : g_bit
        assign mask[i] = (LEN_W'(i) < len_c);
    end

endmodule

// File: rtl/sport_pack_tx.sv
module sport_pack_tx
    import sport_pack_pkg::*;
#(
    parameter int BUF_W_P = BUF_W,
    parameter int SER_W_P = SER_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               port_en,
    input  logic               pack_en,
    input  logic [SER_W_P-1:0] mask,
    input  logic               wr,
    input  logic [BUF_W_P-1:0] wdata,
    input  logic               take,
    output logic [SER_W_P-1:0] sword,
    output logic               sword_vld,
    output logic               full,
    output logic               ovf,
    output logic               irq
);
    tx_state_t s_d, s_q;
    logic take_ok, last_take, room;
    logic [SER_W_P-1:0] half_word;

    always_comb begin
        half_word = s_q.half ? s_q.data[BUF_W_P-1:SER_W_P] : s_q.data[SER_W_P-1:0];
        take_ok   = port_en && take && s_q.full;
        last_take = take_ok && (!pack_en || s_q.half);
        room      = !s_q.full || last_take;

        s_d     = s_q;
        s_d.irq = last_take;
        if (take_ok) begin
            if (last_take) begin
                s_d.full = 1'b0;
                s_d.half = 1'b0;
            end else begin
                s_d.half = 1'b1;
            end
        end
        if (!port_en) begin
            s_d.half = 1'b0;
        end
        if (wr) begin
            if (room) begin
                s_d.data = wdata;
                s_d.full = 1'b1;
            end else begin
                s_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sword_vld = s_q.full && port_en;
    assign sword     = sword_vld ? (half_word & mask) : '0;
    assign full      = s_q.full;
    assign ovf       = s_q.ovf;
    assign irq       = s_q.irq;

    AST_TX_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> full) else $error("tx write did not leave buffer full"); // R2
    AST_TX_IRQ_FROM_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(full)) else $error("tx irq without data"); // R3
    AST_TX_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf) else $error("tx overflow flag dropped"); // R6
    AST_TX_HALF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !s_q.half) else $error("tx half select kept while off"); // R11
    AST_TX_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !sword_vld |-> sword == '0) else $error("tx word not zero when idle"); // R5

endmodule

// File: rtl/sport_pack_rx.sv
module sport_pack_rx
    import sport_pack_pkg::*;
#(
    parameter int BUF_W_P = BUF_W,
    parameter int SER_W_P = SER_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               port_en,
    input  logic               pack_en,
    input  logic [SER_W_P-1:0] mask,
    input  logic               push,
    input  logic [SER_W_P-1:0] sword,
    input  logic               rd,
    output logic [BUF_W_P-1:0] rdata,
    output logic               valid,
    output logic               ovr,
    output logic               irq
);
    localparam int UP_W = BUF_W_P - SER_W_P;

    rx_state_t s_d, s_q;
    logic               hit, room;
    logic [SER_W_P-1:0] w;
    logic [BUF_W_P-1:0] word;

    always_comb begin
        hit  = port_en && push;
        w    = sword & mask;
        room = !s_q.valid || rd;
        word = pack_en ? {w, s_q.lo} : {{UP_W{1'b0}}, w};

        s_d     = s_q;
        s_d.irq = 1'b0;
        if (rd) begin
            s_d.valid = 1'b0;
        end
        if (!port_en) begin
            s_d.half = 1'b0;
        end
        if (hit) begin
            if (pack_en && !s_q.half) begin
                s_d.lo   = w;
                s_d.half = 1'b1;
            end else begin
                s_d.half = 1'b0;
                if (room) begin
                    s_d.data  = word;
                    s_d.valid = 1'b1;
                    s_d.irq   = 1'b1;
                end else begin
                    s_d.ovr = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata = s_q.data;
    assign valid = s_q.valid;
    assign ovr   = s_q.ovr;
    assign irq   = s_q.irq;

    AST_RX_IRQ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> valid) else $error("rx irq without valid"); // R7
    AST_RX_RD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !irq |=> !valid || irq) else $error("rx read left valid"); // R9
    AST_RX_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |=> ovr) else $error("rx overrun flag dropped"); // R10
    AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !pack_en && room |=> rdata[BUF_W_P-1:SER_W_P] == '0) else $error("rx upper half not zero"); // R8
    AST_RX_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> $stable(rdata)) else $error("rx buffer changed while off"); // R11

endmodule

// File: rtl/sport_pack_buf.sv
module sport_pack_buf
    import sport_pack_pkg::*;
#(
    parameter int BUF_W_P = BUF_W,
    parameter int SER_W_P = SER_W,
    parameter int LEN_W_P = LEN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               port_en,
    input  logic               pack_en,
    input  logic [LEN_W_P-1:0] word_len,
    input  logic               tx_wr,
    input  logic [BUF_W_P-1:0] tx_wdata,
    output logic               tx_full,
    output logic               tx_ovf,
    output logic               tx_irq,
    input  logic               tx_take,
    output logic [SER_W_P-1:0] tx_sword,
    output logic               tx_sword_vld,
    input  logic               rx_push,
    input  logic [SER_W_P-1:0] rx_sword,
    input  logic               rx_rd,
    output logic [BUF_W_P-1:0] rx_rdata,
    output logic               rx_valid,
    output logic               rx_ovr,
    output logic               rx_irq
);
    logic [SER_W_P-1:0] mask;

    sport_len_mask #(.SER_W(SER_W_P), .LEN_W(LEN_W_P), .MIN_LEN(MIN_LEN)) i_mask (
        .word_len (word_len),
        .mask     (mask)
    );

    sport_pack_tx #(.BUF_W_P(BUF_W_P), .SER_W_P(SER_W_P)) i_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_en   (port_en),
        .pack_en   (pack_en),
        .mask      (mask),
        .wr        (tx_wr),
        .wdata     (tx_wdata),
        .take      (tx_take),
        .sword     (tx_sword),
        .sword_vld (tx_sword_vld),
        .full      (tx_full),
        .ovf       (tx_ovf),
        .irq       (tx_irq)
    );

    sport_pack_rx #(.BUF_W_P(BUF_W_P), .SER_W_P(SER_W_P)) i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_en (port_en),
        .pack_en (pack_en),
        .mask    (mask),
        .push    (rx_push),
        .sword   (rx_sword),
        .rd      (rx_rd),
        .rdata   (rx_rdata),
        .valid   (rx_valid),
        .ovr     (rx_ovr),
        .irq     (rx_irq)
    );

endmodule

// File: tb/test_sport_pack_buf.sv
module test_sport_pack_buf;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b0, pack_en = 1'b0;
    logic [4:0]  word_len = 5'd16;
    logic        tx_wr = 1'b0, tx_take = 1'b0, rx_push = 1'b0, rx_rd = 1'b0;
    logic [31:0] tx_wdata = '0;
    logic [15:0] rx_sword = '0;
    logic        tx_full, tx_ovf, tx_irq, tx_sword_vld;
    logic [15:0] tx_sword;
    logic [31:0] rx_rdata;
    logic        rx_valid, rx_ovr, rx_irq;

    int total = 0, bad = 0, cycles = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sport_pack_buf i_sport_pack_buf (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .pack_en(pack_en),
        .word_len(word_len), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .tx_full(tx_full), .tx_ovf(tx_ovf), .tx_irq(tx_irq),
        .tx_take(tx_take), .tx_sword(tx_sword), .tx_sword_vld(tx_sword_vld),
        .rx_push(rx_push), .rx_sword(rx_sword), .rx_rd(rx_rd),
        .rx_rdata(rx_rdata), .rx_valid(rx_valid), .rx_ovr(rx_ovr), .rx_irq(rx_irq)
    );

    // behavioural reference state
    logic [31:0] m_tbuf, m_rbuf;
    logic [15:0] m_lo;
    bit m_tfull, m_thalf, m_tovf, m_tirq;
    bit m_rvalid, m_rhalf, m_rovr, m_rirq;

    function automatic logic [15:0] len_mask(input logic [4:0] l);
        int n = int'(l);
        if (n < 3) n = 3;
        if (n > 16) n = 16;
        return 16'((32'd1 << n) - 1);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_tbuf = '0; m_rbuf = '0; m_lo = '0;
            m_tfull = 0; m_thalf = 0; m_tovf = 0; m_tirq = 0;
            m_rvalid = 0; m_rhalf = 0; m_rovr = 0; m_rirq = 0;
        end else begin
            bit ok, fin, freed;
            logic [15:0] w;
            // transmit side
            ok    = port_en && tx_take && m_tfull;
            fin   = ok && (!pack_en || m_thalf);
            freed = !m_tfull || fin;
            m_tirq = fin;
            if (ok) begin
                if (fin) begin m_tfull = 0; m_thalf = 0; end
                else m_thalf = 1;
            end
            if (!port_en) m_thalf = 0;
            if (tx_wr) begin
                if (freed) begin m_tbuf = tx_wdata; m_tfull = 1; end
                else m_tovf = 1;
            end
            // receive side
            m_rirq = 0;
            freed = !m_rvalid || rx_rd;
            if (rx_rd) m_rvalid = 0;
            if (!port_en) m_rhalf = 0;
            w = rx_sword & len_mask(word_len);
            if (port_en && rx_push) begin
                if (pack_en && !m_rhalf) begin
                    m_lo = w; m_rhalf = 1;
                end else begin
                    m_rhalf = 0;
                    if (freed) begin
                        m_rbuf = pack_en ? {w, m_lo} : {16'h0, w};
                        m_rvalid = 1; m_rirq = 1;
                    end else m_rovr = 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            logic [15:0] ew;
            bit ev;
            ev = m_tfull && port_en;
            ew = ev ? ((m_thalf ? m_tbuf[31:16] : m_tbuf[15:0]) & len_mask(word_len)) : 16'h0;
            check("R2 tx_full", 32'(tx_full), 32'(m_tfull));
            check("R6 tx_ovf", 32'(tx_ovf), 32'(m_tovf));
            check("R3 tx_irq", 32'(tx_irq), 32'(m_tirq));
            check("R11 tx_sword_vld", 32'(tx_sword_vld), 32'(ev));
            check("R5 tx_sword", 32'(tx_sword), 32'(ew));
            check("R7 rx_rdata", rx_rdata, m_rbuf);
            check("R9 rx_valid", 32'(rx_valid), 32'(m_rvalid));
            check("R10 rx_ovr", 32'(rx_ovr), 32'(m_rovr));
            check("R8 rx_irq", 32'(rx_irq), 32'(m_rirq));
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
        tx_wr = 0; tx_take = 0; rx_push = 0; rx_rd = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 tx_full", 32'(tx_full), 0);
        check("R1 tx_ovf", 32'(tx_ovf), 0);
        check("R1 tx_irq", 32'(tx_irq), 0);
        check("R1 tx_sword_vld", 32'(tx_sword_vld), 0);
        check("R1 rx_valid", 32'(rx_valid), 0);
        check("R1 rx_rdata", rx_rdata, 0);
        check("R1 rx_flags", {30'h0, rx_ovr, rx_irq}, 0);
        rst_n = 1; port_en = 1; pack_en = 0; word_len = 16;
        cmp_on = 1;
        step();

        // R4 and R12: one take empties, write in the same cycle is accepted
        tx_wr = 1; tx_wdata = 32'hABCD_1234; step();
        check("R4 first word", 32'(tx_sword), 32'h1234);
        tx_take = 1; tx_wr = 1; tx_wdata = 32'h0000_5678; step();
        check("R12 tx refill full", 32'(tx_full), 1);
        check("R12 tx no ovf", 32'(tx_ovf), 0);
        check("R12 tx irq", 32'(tx_irq), 1);
        check("R4 next word", 32'(tx_sword), 32'h5678);
        tx_take = 1; step();

        // R3: packed transmit order, length 8
        pack_en = 1; word_len = 8;
        tx_wr = 1; tx_wdata = 32'h12F0_34A5; step();
        check("R3 low half first", 32'(tx_sword), 32'h00A5);
        tx_take = 1; step();
        check("R3 still full", 32'(tx_full), 1);
        check("R3 high half", 32'(tx_sword), 32'h00F0);
        tx_take = 1; step();
        check("R3 empty after two", 32'(tx_full), 0);

        // R7: packed receive with masking
        rx_push = 1; rx_sword = 16'h01FF; step();
        check("R7 not valid after one", 32'(rx_valid), 0);
        rx_push = 1; rx_sword = 16'h02AB; step();
        check("R7 packed word", rx_rdata, 32'h00AB_00FF);
        check("R7 irq", 32'(rx_irq), 1);
        // R12: completing push together with read
        rx_push = 1; rx_sword = 16'h0011; step();
        rx_push = 1; rx_sword = 16'h0022; rx_rd = 1; step();
        check("R12 rx refill", rx_rdata, 32'h0022_0011);
        check("R12 rx no ovr", 32'(rx_ovr), 0);
        // R11: port off, push ignored, read still clears status
        port_en = 0; rx_push = 1; rx_sword = 16'h0033; rx_rd = 1; step();
        check("R11 rx held", rx_rdata, 32'h0022_0011);
        check("R9 read while off", 32'(rx_valid), 0);
        port_en = 1; step();

        // random phases
        for (int p = 0; p < 6; p++) begin
            pack_en = p[0];
            case (p)
                0: word_len = 16; 1: word_len = 8; 2: word_len = 3;
                3: word_len = 12; 4: word_len = 1; default: word_len = 25;
            endcase
            for (int c = 0; c < 2000; c++) begin
                port_en  = ($urandom_range(0, 99) < 94);
                tx_wr    = ($urandom_range(0, 99) < 30);
                tx_wdata = $urandom;
                tx_take  = ($urandom_range(0, 99) < 45);
                rx_push  = ($urandom_range(0, 99) < 45);
                rx_sword = 16'($urandom);
                rx_rd    = ($urandom_range(0, 99) < 25);
                if (c % 500 == 250) pack_en = ~pack_en;
                @(posedge clk);
                #1;
            end
        end
        tx_wr = 0; tx_take = 0; rx_push = 0; rx_rd = 0;
        step();
        cmp_on = 0;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule